// File: doc/BRIEF.md
# Streaming COBS Frame Decoder

This block turns a byte stream of consistent-overhead-byte-stuffed frames back into raw packets. Frames on the input are separated by 0x00 bytes. Each frame is a chain of segments. A segment opens with a code byte, and the code byte says how many literal bytes follow it. Decoded bytes leave on a byte-wide AXI4-Stream output. tlast marks the final byte of each packet, and tuser marks a packet whose frame was cut short.

Decoding happens on the fly and uses no frame buffer. A down-counter tracks how many literal bytes remain in the current segment. A single pending-zero flag records whether an implied zero is owed when the next segment starts. One decoded byte is always held back in a staging register. It is released only when the next input byte or the delimiter shows whether it is the final byte of the packet. This lets tlast land on the true last byte. It also means the implied zero that trails the last segment is never emitted.

Top module: `cobs_frame_decoder`

## Requirements
- R1: After a code byte of value c, the next c-1 input bytes appear on the output unchanged and in order.
- R2: When a segment whose code is below 0xFF is followed by another code byte in the same frame, one 0x00 byte is output between the two segments' data.
- R3: A segment with code 0xFF is followed by no inserted 0x00.
- R4: The implied zero that trails the last segment of a frame is never output, and tlast is 1 only on the final decoded byte of each packet.
- R5: When the delimiter (0x00) arrives while the current segment still expects literal bytes, the last byte already decoded is output with tlast=1 and tuser=1. All earlier bytes of that packet carry tuser=0.
- R6: When a frame is truncated and no decoded byte is waiting, a single 0x00 byte is output with tlast=1 and tuser=1.
- R7: A frame that decodes to no bytes and is not truncated produces no output. This covers a delimiter right after another delimiter, and a frame made only of code 0x01.
- R8: While m_tvalid_o=1 and m_tready_i=0, the output data, tlast and tuser stay stable and m_tvalid_o stays 1.
- R9: s_tready_o is 0 whenever the output holds a beat that is not being taken (m_tvalid_o=1, m_tready_i=0).
- R10: Asserting rst_ni low clears the output (m_tvalid_o=0), drops any staged byte, and returns the decoder to expect a code byte at the start of a new frame.
- R11: tuser is 1 only on a beat that also has tlast=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 8 | Encoded input byte; 0x00 ends a frame |
| s_tvalid_i | input | 1 | Input byte valid |
| s_tready_o | output | 1 | Input byte accepted when high with s_tvalid_i |
| m_tdata_o | output | 8 | Decoded byte |
| m_tvalid_o | output | 1 | Decoded byte valid |
| m_tready_i | input | 1 | Downstream ready |
| m_tlast_o | output | 1 | Final byte of a decoded packet |
| m_tuser_o | output | 1 | Packet came from a truncated frame |

## Verification
The assertions assume standard stream behaviour at the input. Once s_tvalid_i is raised, it and s_tdata_i hold until the handshake completes. The checks of output stability and input stalling also rely on m_tready_i being sampled as a plain level at each edge. The stimulus keeps to these rules by loading a byte into a holding slot and driving it unchanged until it is accepted. Valid gaps and ready backpressure are drawn at random each cycle. Encoded frames come from a bench encoder, with tails dropped at random to produce truncation.

// File: rtl/cobs_dec_pkg.sv
package cobs_dec_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] DELIM_BYTE = '0;
  localparam logic [BYTE_W-1:0] LONG_CODE  = '1;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  user;
    logic  last;
    byte_t data;
  } beat_t;
endpackage

// File: rtl/cobs_seg_tracker.sv
module cobs_seg_tracker
  import cobs_dec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  byte_t byte_i,
  output logic  is_delim_o,
  output logic  is_code_o,
  output logic  is_data_o,
  output logic  zero_due_o,
  output logic  trunc_o
);
  logic  want_code_q;
  logic  zero_pend_q;
  byte_t left_q;

  assign is_delim_o = (byte_i == DELIM_BYTE);
  assign is_code_o  = !is_delim_o && want_code_q;
  assign is_data_o  = !is_delim_o && !want_code_q;
  assign zero_due_o = zero_pend_q;
  assign trunc_o    = !want_code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_code_q <= 1'b1;
      zero_pend_q <= 1'b0;
      left_q      <= '0;
    end else if (acc_i) begin
      if (is_delim_o) begin
        want_code_q <= 1'b1;
        zero_pend_q <= 1'b0;
        left_q      <= '0;
      end else if (want_code_q) begin
        left_q      <= byte_i - byte_t'(1);
        want_code_q <= (byte_i == byte_t'(1));
        zero_pend_q <= (byte_i != LONG_CODE);
      end else begin
        left_q <= left_q - byte_t'(1);
        if (left_q == byte_t'(1)) want_code_q <= 1'b1;
      end
    end
  end

  // R1
  seg_left_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_code_q |-> (left_q != '0));

  // R3
  long_code_no_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && is_code_o && byte_i == LONG_CODE) |=> !zero_pend_q);
endmodule

// File: rtl/cobs_stage.sv
module cobs_stage
  import cobs_dec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  byte_t byte_i,
  input  logic  is_delim_i,
  input  logic  is_code_i,
  input  logic  is_data_i,
  input  logic  zero_due_i,
  input  logic  trunc_i,
  output logic  stg_valid_o,
  output logic  push_o,
  output beat_t push_beat_o
);
  logic  stg_v_q;
  byte_t stg_d_q;

  assign stg_valid_o = stg_v_q;

  always_comb begin
    push_o      = 1'b0;
    push_beat_o = '0;
    if (acc_i) begin
      if (is_delim_i) begin
        if (stg_v_q) begin
          push_o      = 1'b1;
          push_beat_o = '{user: trunc_i, last: 1'b1, data: stg_d_q};
        end else if (trunc_i) begin
          // nothing decoded yet: mark the cut frame with a filler byte
          push_o      = 1'b1;
          push_beat_o = '{user: 1'b1, last: 1'b1, data: DELIM_BYTE};
        end
      end else if ((is_code_i && zero_due_i) || is_data_i) begin
        push_o      = stg_v_q;
        push_beat_o = '{user: 1'b0, last: 1'b0, data: stg_d_q};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v_q <= 1'b0;
      stg_d_q <= '0;
    end else if (acc_i) begin
      if (is_delim_i) begin
        stg_v_q <= 1'b0;
      end else if (is_code_i && zero_due_i) begin
        stg_v_q <= 1'b1;
        stg_d_q <= DELIM_BYTE;
      end else if (is_data_i) begin
        stg_v_q <= 1'b1;
        stg_d_q <= byte_i;
      end
    end
  end

  // R4
  last_only_on_delim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_beat_o.last) |-> (acc_i && is_delim_i));

  // R2
  zero_staged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && is_code_i && zero_due_i) |=> (stg_v_q && stg_d_q == DELIM_BYTE));
endmodule

// File: rtl/cobs_out_reg.sv
module cobs_out_reg
  import cobs_dec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  beat_t beat_i,
  input  logic  m_tready_i,
  output logic  m_tvalid_o,
  output beat_t m_beat_o,
  output logic  free_o
);
  assign free_o = !m_tvalid_o || m_tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tvalid_o <= 1'b0;
      m_beat_o   <= '0;
    end else if (push_i) begin
      m_tvalid_o <= 1'b1;
      m_beat_o   <= beat_i;
    end else if (m_tready_i) begin
      m_tvalid_o <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_beat_o)));

  // R9
  no_push_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> free_o);

  // R11
  user_with_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && m_beat_o.user) |-> m_beat_o.last);
endmodule

// File: rtl/cobs_frame_decoder.sv
module cobs_frame_decoder
  import cobs_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BYTE_W-1:0] s_tdata_i,
  input  logic             s_tvalid_i,
  output logic             s_tready_o,
  output logic [BYTE_W-1:0] m_tdata_o,
  output logic             m_tvalid_o,
  input  logic             m_tready_i,
  output logic             m_tlast_o,
  output logic             m_tuser_o
);
  logic  acc;
  logic  is_delim, is_code, is_data, zero_due, trunc;
  logic  stg_valid, push, free;
  beat_t push_beat, out_beat;

  assign s_tready_o = free;
  assign acc        = s_tvalid_i && free;

  cobs_seg_tracker u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .byte_i     (s_tdata_i),
    .is_delim_o (is_delim),
    .is_code_o  (is_code),
    .is_data_o  (is_data),
    .zero_due_o (zero_due),
    .trunc_o    (trunc)
  );

  cobs_stage u_stg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .byte_i      (s_tdata_i),
    .is_delim_i  (is_delim),
    .is_code_i   (is_code),
    .is_data_i   (is_data),
    .zero_due_i  (zero_due),
    .trunc_i     (trunc),
    .stg_valid_o (stg_valid),
    .push_o      (push),
    .push_beat_o (push_beat)
  );

  cobs_out_reg u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .beat_i     (push_beat),
    .m_tready_i (m_tready_i),
    .m_tvalid_o (m_tvalid_o),
    .m_beat_o   (out_beat),
    .free_o     (free)
  );

  assign m_tdata_o = out_beat.data;
  assign m_tlast_o = out_beat.last;
  assign m_tuser_o = out_beat.user;

  // R7
  empty_frame_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_delim && !stg_valid && !trunc) |=> !m_tvalid_o);

  // R5
  trunc_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_delim && trunc) |=> (m_tvalid_o && m_tlast_o && m_tuser_o));
endmodule

// File: tb/tb_cobs_frame_decoder.sv
module tb_cobs_frame_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] s_tdata_i = '0;
  logic       s_tvalid_i = 1'b0;
  logic       s_tready_o;
  logic [7:0] m_tdata_o;
  logic       m_tvalid_o;
  logic       m_tready_i = 1'b0;
  logic       m_tlast_o;
  logic       m_tuser_o;

  always #5 clk_i = ~clk_i;

  cobs_frame_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_tdata_i(s_tdata_i), .s_tvalid_i(s_tvalid_i), .s_tready_o(s_tready_o),
    .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i),
    .m_tlast_o(m_tlast_o), .m_tuser_o(m_tuser_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int vprob = 100, rprob = 100;
  logic [7:0] raw_q[$], enc_q[$], tx_q[$];
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] hold_d = '0;
  logic       hold_v = 1'b0;
  logic [9:0] prev_beat = '0;
  logic       prev_stall = 1'b0;
  localparam int CYC_LIMIT = 150000;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic encode();
    automatic logic [7:0] blk[$];
    automatic int code = 1;
    enc_q.delete();
    foreach (raw_q[i]) begin
      if (raw_q[i] == 8'h00) begin
        enc_q.push_back(8'(code)); foreach (blk[k]) enc_q.push_back(blk[k]);
        blk.delete(); code = 1;
      end else begin
        blk.push_back(raw_q[i]); code++;
        if (code == 255) begin
          enc_q.push_back(8'(code)); foreach (blk[k]) enc_q.push_back(blk[k]);
          blk.delete(); code = 1;
        end
      end
    end
    enc_q.push_back(8'(code)); foreach (blk[k]) enc_q.push_back(blk[k]);
  endtask

  // frame-level model of the requirements
  task automatic add_enc(input string tag);
    automatic logic [7:0] dec[$];
    automatic int i = 0, code = 0, prev = 0;
    automatic bit first = 1, mal = 0;
    while (i < enc_q.size()) begin
      code = int'(enc_q[i]); i++;
      if (!first && prev != 255) dec.push_back(8'h00);
      first = 0; prev = code;
      for (int k = 1; k < code; k++) begin
        if (i >= enc_q.size()) begin mal = 1; break; end
        dec.push_back(enc_q[i]); i++;
      end
    end
    if (dec.size() == 0) begin
      if (mal) begin exp_q.push_back({1'b1, 1'b1, 8'h00}); tag_q.push_back({tag, "/R6"}); end
    end else begin
      foreach (dec[j]) begin
        automatic bit l = (j == dec.size() - 1);
        exp_q.push_back({l & mal, l, dec[j]});
        tag_q.push_back(l ? (mal ? {tag, "/R5"} : {tag, "/R4"}) : {tag, "/R1"});
      end
    end
    foreach (enc_q[j]) tx_q.push_back(enc_q[j]);
    tx_q.push_back(8'h00);
  endtask

  task automatic add_frame(input int drop, input string tag);
    encode();
    for (int d = 0; d < drop && enc_q.size() > 0; d++) void'(enc_q.pop_back());
    add_enc(tag);
  endtask

  task automatic step();
    logic [9:0] beat;
    @(negedge clk_i);
    cyc++;
    m_tready_i = ($urandom_range(99) < rprob);
    if (!hold_v && tx_q.size() > 0 && $urandom_range(99) < vprob) begin
      hold_d = tx_q.pop_front(); hold_v = 1'b1;
    end
    s_tvalid_i = hold_v;
    s_tdata_i  = hold_d;
    #1;
    beat = {m_tuser_o, m_tlast_o, m_tdata_o};
    if (prev_stall) chk(m_tvalid_o && beat == prev_beat, "R8", "stalled beat changed", int'(beat), int'(prev_beat));
    prev_stall = m_tvalid_o && !m_tready_i;
    prev_beat  = beat;
    if (m_tvalid_o && !m_tready_i) chk(!s_tready_o, "R9", "ready while stalled", int'(s_tready_o), 0);
    if (m_tvalid_o && m_tready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected beat", int'(beat), 0);
      else begin
        automatic logic [9:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(beat == e, t, "beat {user,last,data}", int'(beat), int'(e));
        chk(!m_tuser_o || m_tlast_o, "R11", "user without last", int'(beat), 0);
      end
    end
    if (s_tvalid_i && s_tready_o) hold_v = 1'b0;
  endtask

  task automatic drain();
    while ((tx_q.size() > 0 || hold_v || exp_q.size() > 0) && cyc < CYC_LIMIT) step();
    repeat (8) step();
    if (cyc >= CYC_LIMIT) chk(1'b0, "WDOG", "drain timeout", cyc, CYC_LIMIT);
  endtask

  task automatic set_enc(input logic [7:0] b[$]);
    enc_q = b;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0b5));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk(m_tvalid_o == 1'b0, "R10", "valid after reset", int'(m_tvalid_o), 0);
    chk(s_tready_o == 1'b1, "R10", "ready after reset", int'(s_tready_o), 1);

    set_enc('{8'h03, 8'h41, 8'h42}); add_enc("R1");
    set_enc('{8'h02, 8'h11, 8'h02, 8'h22}); add_enc("R2");
    set_enc('{8'h03, 8'h41, 8'h42, 8'h01}); add_enc("R2");
    set_enc('{8'h01, 8'h01}); add_enc("R2");
    set_enc('{8'h02, 8'h55}); add_enc("R4");
    tx_q.push_back(8'h00); // R7 back-to-back delimiter
    set_enc('{8'h01}); add_enc("R7");
    set_enc('{8'h05, 8'h61, 8'h62}); add_enc("R5");
    set_enc('{8'h02, 8'h11, 8'h03}); add_enc("R5");
    set_enc('{8'h04}); add_enc("R6");
    raw_q.delete();
    for (int i = 1; i <= 254; i++) raw_q.push_back(8'(i));
    raw_q.push_back(8'h77);
    add_frame(0, "R3");
    drain();

    // R10 reset mid-frame discards staged state
    tx_q.push_back(8'h05); tx_q.push_back(8'h11);
    drain();
    @(negedge clk_i);
    s_tvalid_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1; prev_stall = 1'b0;
    #1 chk(m_tvalid_o == 1'b0, "R10", "valid after mid-frame reset", int'(m_tvalid_o), 0);
    set_enc('{8'h02, 8'h33}); add_enc("R10");
    drain();

    for (int f = 0; f < 200; f++) begin
      automatic int len = ($urandom_range(19) == 0) ? 300 + $urandom_range(40) : $urandom_range(40);
      automatic int zp = ($urandom_range(3) == 0) ? 0 : 30;
      vprob = 40 + $urandom_range(60);
      rprob = 30 + $urandom_range(70);
      raw_q.delete();
      for (int i = 0; i < len; i++)
        raw_q.push_back(($urandom_range(99) < zp) ? 8'h00 : 8'($urandom_range(1, 255)));
      add_frame(($urandom_range(9) == 0) ? $urandom_range(1, 4) : 0, "RND");
      if ($urandom_range(15) == 0) tx_q.push_back(8'h00);
      if (f % 10 == 9) drain();
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_tests++; n_fail++;
    $display("FAIL WDOG watchdog expired actual=%0d expected=%0d", cyc, CYC_LIMIT);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule